// File: doc/BRIEF.md
# CPU Idle/Stop Power Controller

This block decides when the CPU runs, when it pauses and when the internal oscillator and peripheral clocks are switched off. Software writes a two-bit power control register. Bit 0 requests idle and bit 1 requests stop.

- **Idle** halts instruction execution at once. Clocks and peripherals keep running. Any enabled interrupt ends idle, and the hardware clears bit 0 when it does.
- **Stop** waits until the instruction that wrote the register signals that it has completed. The block then halts the CPU and drops the oscillator enable and the peripheral clock enable. Only a reset can end stop.

The block combines all reset sources into one internal reset request:

- an external reset input;
- a watchdog expiry, when the watchdog is enabled;
- a missing-clock detector.

The missing-clock detector runs from an always-on reference tick. It counts those ticks and clears the count on every observed system-clock edge. When the count reaches a parameterised timeout, it raises the internal reset. This is how a stopped or dead system clock leads back to the run state.

The block runs on an always-on controller clock. Every input is a single-cycle strobe or level sampled on that clock. Clock generation and the CPU core sit outside the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous reset `rst` the block is in run mode: `pcon_rd`=2'b00, `cpu_halt`=0, `osc_en`=1, `periph_clk_en`=1, `int_rst_req`=0.
- R2: In run mode, a write with `pcon_wdata`=2'b01 (bit 0 = idle) enters idle on the next cycle: `pcon_rd`=2'b01, `cpu_halt`=1, while `osc_en` and `periph_clk_en` stay 1.
- R3: In idle, any source with both `irq_req` and `irq_en` set returns the block to run on the next cycle with bit 0 cleared (`pcon_rd`=2'b00, `cpu_halt`=0). A request whose enable is 0 has no effect.
- R4: In run mode, a write with bit 1 set (stop) makes `pcon_rd`=2'b10 on the next cycle, but `cpu_halt` stays 0 and the clocks stay on. Stop is entered (`cpu_halt`=1, `osc_en`=0, `periph_clk_en`=0) on the cycle after the first `instr_done` strobe that follows the write.
- R5: In stop, interrupt requests, register writes and watchdog expiry have no effect.
- R6: `ext_rst` returns the block from any mode to run on the next cycle with `pcon_rd`=2'b00. It does not raise `int_rst_req`.
- R7: A write of 2'b11 is treated as a stop request: `pcon_rd` becomes 2'b10 and idle is not entered.
- R8: When `wdt_en`=1 and `wdt_expire`=1 in run, idle or stop-pending, `int_rst_req` pulses for one cycle together with `pcon_rd`=2'b00 and run mode. When `wdt_en`=0, expiry has no effect.
- R9: When `mcd_en`=1 and `MCD_TICKS` consecutive `ref_tick` strobes pass with no `sysclk_edge`, `int_rst_req` pulses and the block returns to run. This also ends stop.
- R10: A `sysclk_edge` restarts the missing-clock count. When `mcd_en`=0, the detector never fires.
- R11: Register writes are accepted only in run mode. Writes during idle or while a stop is pending have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pcon_wr | input | 1 | Power control register write strobe |
| pcon_wdata | input | 2 | Write data: bit 1 stop, bit 0 idle |
| instr_done | input | 1 | Current instruction completed |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| ext_rst | input | 1 | External reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| mcd_en | input | 1 | Missing-clock detector enable |
| ref_tick | input | 1 | Always-running reference tick strobe |
| sysclk_edge | input | 1 | One system-clock edge observed |
| pcon_rd | output | 2 | Power control register contents |
| cpu_halt | output | 1 | CPU instruction execution halted |
| osc_en | output | 1 | Internal oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| int_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The mode sequencer is driven through a vector sequence. It enters idle and leaves it by a masked request and then by an enabled one, which separates the mask from the request. It requests stop with and without the completion strobe, which separates the pending state from stop itself. It issues a combined 2'b11 write to show that stop takes precedence. It offers interrupts, writes and watchdog expiry during stop, which separates the wake paths that stop must close from those that stay open in idle. The missing-clock detector is run to one tick short of its timeout and then to the timeout itself, to fix the exact firing cycle. It is then restarted by a system-clock edge and run while disabled, to show that only an unbroken run of ticks fires it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN       = 2'd0,
        PM_IDLE      = 2'd1,
        PM_STOP_PEND = 2'd2,
        PM_STOP      = 2'd3
    } pm_state_e;

    localparam int PCON_W   = 2;
    localparam int IDLE_BIT = 0;
    localparam int STOP_BIT = 1;

    typedef struct packed {
        logic halt;
        logic osc;
        logic periph;
    } pm_out_t;

    // Per-mode drive of the halt and clock-gate outputs.
    function automatic pm_out_t mode_outputs(pm_state_e s);
        pm_out_t o;
        case (s)
            PM_IDLE: o = '{halt: 1'b1, osc: 1'b1, periph: 1'b1};
            PM_STOP: o = '{halt: 1'b1, osc: 1'b0, periph: 1'b0};
            default: o = '{halt: 1'b0, osc: 1'b1, periph: 1'b1};
        endcase
        return o;
    endfunction

    // Stop outranks idle when both request bits arrive together.
    function automatic pm_state_e decode_write(logic [PCON_W-1:0] d);
        if (d[STOP_BIT])      return PM_STOP_PEND;
        else if (d[IDLE_BIT]) return PM_IDLE;
        else                  return PM_RUN;
    endfunction

endpackage

// File: rtl/pwr_mcd.sv
module pwr_mcd #(
    parameter int MCD_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic mcd_en,
    input  logic ref_tick,
    input  logic sysclk_edge,
    output logic fire
);
    localparam int CW = $clog2(MCD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MCD_TICKS - 1);

    logic [CW-1:0] cnt;

    assign fire = mcd_en && ref_tick && !sysclk_edge && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !mcd_en || sysclk_edge || fire)
            cnt <= '0;
        else if (ref_tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_wake.sv
module pwr_wake #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_en,
    input  logic             wdt_expire,
    output logic             wake,
    output logic             wdt_rst
);
    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign wake    = |live;
    assign wdt_rst = wdt_en & wdt_expire;
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pcon_wr,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              instr_done,
    input  logic              wake,
    input  logic              wdt_rst,
    input  logic              mcd_fire,
    input  logic              ext_rst,
    output pm_state_e         state,
    output logic [PCON_W-1:0] pcon,
    output logic              int_rst_req
);
    pm_state_e         state_n;
    logic [PCON_W-1:0] pcon_n;
    logic              int_src;

    // The watchdog stops together with the peripherals in stop.
    assign int_src = (wdt_rst && state != PM_STOP) || mcd_fire;

    always_comb begin
        state_n = state;
        pcon_n  = pcon;
        if (ext_rst || int_src) begin
            state_n = PM_RUN;
            pcon_n  = '0;
        end else begin
            case (state)
                PM_RUN: if (pcon_wr) begin
                    state_n = decode_write(pcon_wdata);
                    pcon_n  = '0;
                    if (pcon_wdata[STOP_BIT])      pcon_n[STOP_BIT] = 1'b1;
                    else if (pcon_wdata[IDLE_BIT]) pcon_n[IDLE_BIT] = 1'b1;
                end
                PM_IDLE: if (wake) begin
                    state_n          = PM_RUN;
                    pcon_n[IDLE_BIT] = 1'b0;
                end
                PM_STOP_PEND: if (instr_done) state_n = PM_STOP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PM_RUN;
            pcon        <= '0;
            int_rst_req <= 1'b0;
        end else begin
            state       <= state_n;
            pcon        <= pcon_n;
            int_rst_req <= int_src && !ext_rst;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ     = 4,
    parameter int MCD_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pcon_wr,
    input  logic [1:0]       pcon_wdata,
    input  logic             instr_done,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ext_rst,
    input  logic             wdt_en,
    input  logic             wdt_expire,
    input  logic             mcd_en,
    input  logic             ref_tick,
    input  logic             sysclk_edge,
    output logic [1:0]       pcon_rd,
    output logic             cpu_halt,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic             int_rst_req
);
    logic      wake, wdt_rst, mcd_fire;
    pm_state_e state;
    pm_out_t   outs;

    pwr_wake #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .wdt_en    (wdt_en),
        .wdt_expire(wdt_expire),
        .wake      (wake),
        .wdt_rst   (wdt_rst)
    );

    pwr_mcd #(.MCD_TICKS(MCD_TICKS)) u_mcd (
        .clk        (clk),
        .rst        (rst),
        .clr        (ext_rst),
        .mcd_en     (mcd_en),
        .ref_tick   (ref_tick),
        .sysclk_edge(sysclk_edge),
        .fire       (mcd_fire)
    );

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pcon_wr    (pcon_wr),
        .pcon_wdata (pcon_wdata),
        .instr_done (instr_done),
        .wake       (wake),
        .wdt_rst    (wdt_rst),
        .mcd_fire   (mcd_fire),
        .ext_rst    (ext_rst),
        .state      (state),
        .pcon       (pcon_rd),
        .int_rst_req(int_rst_req)
    );

    assign outs          = mode_outputs(state);
    assign cpu_halt      = outs.halt;
    assign osc_en        = outs.osc;
    assign periph_clk_en = outs.periph;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_done,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             ext_rst,
    input logic             wdt_en,
    input logic             wdt_expire,
    input logic             mcd_en,
    input logic [1:0]       pcon_rd,
    input logic             cpu_halt,
    input logic             osc_en,
    input logic             periph_clk_en,
    input logic             int_rst_req
);
    AST_IDLE_BIT: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && osc_en) |-> (pcon_rd == 2'b01));  // R2

    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && osc_en && |(irq_req & irq_en)) |=> !cpu_halt);  // R3

    AST_CLK_GATES: assert property (@(posedge clk) disable iff (rst)
        (osc_en == periph_clk_en) && (osc_en || cpu_halt));  // R4

    AST_STOP_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pcon_rd == 2'b10 && !cpu_halt && !instr_done && !ext_rst && !mcd_en
         && !(wdt_en && wdt_expire)) |=> (pcon_rd == 2'b10 && !cpu_halt));  // R4

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !ext_rst && !mcd_en) |=> !osc_en);  // R5

    AST_EXT_RST_RUN: assert property (@(posedge clk) disable iff (rst)
        ext_rst |=> (pcon_rd == 2'b00 && !cpu_halt && !int_rst_req));  // R6

    AST_INT_RST_RUN: assert property (@(posedge clk) disable iff (rst)
        int_rst_req |-> (pcon_rd == 2'b00 && !cpu_halt && osc_en));  // R8
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_done   (instr_done),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .ext_rst      (ext_rst),
    .wdt_en       (wdt_en),
    .wdt_expire   (wdt_expire),
    .mcd_en       (mcd_en),
    .pcon_rd      (pcon_rd),
    .cpu_halt     (cpu_halt),
    .osc_en       (osc_en),
    .periph_clk_en(periph_clk_en),
    .int_rst_req  (int_rst_req)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
    localparam int NI    = 4;
    localparam int MCD_T = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pcon_wr = 1'b0;
    logic [1:0]    pcon_wdata = '0;
    logic          instr_done = 1'b0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic          ext_rst = 1'b0, wdt_en = 1'b0, wdt_expire = 1'b0;
    logic          mcd_en = 1'b0, ref_tick = 1'b0, sysclk_edge = 1'b0;
    logic [1:0]    pcon_rd;
    logic          cpu_halt, osc_en, periph_clk_en, int_rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .MCD_TICKS(MCD_T)) u_dut (
        .clk(clk), .rst(rst), .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata),
        .instr_done(instr_done), .irq_req(irq_req), .irq_en(irq_en),
        .ext_rst(ext_rst), .wdt_en(wdt_en), .wdt_expire(wdt_expire),
        .mcd_en(mcd_en), .ref_tick(ref_tick), .sysclk_edge(sysclk_edge),
        .pcon_rd(pcon_rd), .cpu_halt(cpu_halt), .osc_en(osc_en),
        .periph_clk_en(periph_clk_en), .int_rst_req(int_rst_req)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          wr;
        logic [1:0]    wd;
        logic          done;
        logic [NI-1:0] irq;
        logic [NI-1:0] ien;
        logic          xr;
        logic          we;
        logic          wx;
        logic [1:0]    e_pcon;
        logic          e_halt;
        logic          e_osc;
        logic          e_irst;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0}, // R1 idle-free run
        '{4'd2,  1'b1, 2'b01, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0}, // R2 enter idle
        '{4'd11, 1'b1, 2'b10, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0}, // R11 write in idle
        '{4'd3,  1'b0, 2'b00, 1'b0, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0}, // R3 masked irq
        '{4'd3,  1'b0, 2'b00, 1'b0, 4'h4, 4'h4, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0}, // R3 enabled irq wakes
        '{4'd4,  1'b1, 2'b10, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0}, // R4 stop pending
        '{4'd11, 1'b1, 2'b01, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0}, // R11 write while pending
        '{4'd4,  1'b0, 2'b00, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}, // R4 done -> stop
        '{4'd5,  1'b0, 2'b00, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}, // R5 irq in stop
        '{4'd5,  1'b1, 2'b01, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}, // R5 write in stop
        '{4'd5,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0}, // R5 wdt in stop
        '{4'd6,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0}, // R6 ext reset ends stop
        '{4'd7,  1'b1, 2'b11, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0}, // R7 both bits
        '{4'd7,  1'b0, 2'b00, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}, // R7 becomes stop
        '{4'd6,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0}, // R6 ext reset again
        '{4'd2,  1'b1, 2'b01, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0}, // R2 idle again
        '{4'd8,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0}, // R8 wdt disabled
        '{4'd8,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1}, // R8 wdt ends idle
        '{4'd8,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0}, // R8 pulse is single
        '{4'd8,  1'b0, 2'b00, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1}  // R8 wdt in run
    };

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {pcon,halt,osc,irst} got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] obs();
        return {pcon_rd, cpu_halt, osc_en & periph_clk_en, int_rst_req};
    endfunction

    task automatic quiet();
        pcon_wr = 1'b0; pcon_wdata = '0; instr_done = 1'b0;
        irq_req = '0; irq_en = '0; ext_rst = 1'b0;
        wdt_en = 1'b0; wdt_expire = 1'b0; sysclk_edge = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
        end
    endtask

    localparam logic [4:0] RUN_Q  = 5'b00_0_1_0;
    localparam logic [4:0] RUN_RS = 5'b00_0_1_1;
    localparam logic [4:0] STOP_Q = 5'b10_1_0_0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", obs(), RUN_Q);

        for (int k = 0; k < NV; k++) begin
            pcon_wr = VECS[k].wr; pcon_wdata = VECS[k].wd; instr_done = VECS[k].done;
            irq_req = VECS[k].irq; irq_en = VECS[k].ien; ext_rst = VECS[k].xr;
            wdt_en = VECS[k].we; wdt_expire = VECS[k].wx;
            @(negedge clk);
            n_tests++;
            if (obs() !== {VECS[k].e_pcon, VECS[k].e_halt, VECS[k].e_osc, VECS[k].e_irst}) begin
                n_fail++;
                $display("FAIL R%0d step %0d: got %b expected %b", VECS[k].req, k, obs(),
                         {VECS[k].e_pcon, VECS[k].e_halt, VECS[k].e_osc, VECS[k].e_irst});
            end
        end
        quiet();

        // R9: detector in run, one tick short then the timeout tick
        mcd_en = 1'b1;
        ticks(MCD_T - 1);
        chk("R9 one short of timeout", obs(), RUN_Q);
        ticks(1);
        chk("R9 timeout fires", obs(), RUN_RS);
        ref_tick = 1'b0;
        @(negedge clk);

        // R10: a system-clock edge restarts the count
        ticks(MCD_T - 1);
        sysclk_edge = 1'b1;
        ticks(1);
        sysclk_edge = 1'b0;
        ticks(MCD_T - 1);
        chk("R10 restart by sysclk edge", obs(), RUN_Q);
        ticks(1);
        chk("R10 fires after restart", obs(), RUN_RS);

        // R10: disabled detector never fires
        mcd_en = 1'b0;
        ticks(3 * MCD_T);
        chk("R10 disabled detector", obs(), RUN_Q);
        ref_tick = 1'b0;

        // R9: detector ends stop
        pcon_wr = 1'b1; pcon_wdata = 2'b10;
        @(negedge clk);
        pcon_wr = 1'b0; instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        chk("R4 stop entered", obs(), STOP_Q);
        mcd_en = 1'b1;
        ticks(MCD_T - 1);
        chk("R9 stop before timeout", obs(), STOP_Q);
        ticks(1);
        chk("R9 timeout ends stop", obs(), RUN_RS);
        ref_tick = 1'b0; mcd_en = 1'b0;
        @(negedge clk);

        // R1: reset from idle
        pcon_wr = 1'b1; pcon_wdata = 2'b01;
        @(negedge clk);
        pcon_wr = 1'b0;
        chk("R2 idle before reset", obs(), 5'b01_1_1_0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset from idle", obs(), RUN_Q);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule